// File: doc/BRIEF.md
# Compressed-Table Sine Synthesizer

This block is the digital core of a direct digital synthesizer. A 32-bit phase register advances by a programmable tuning word on every clock. The top 12 bits of that phase drive a phase-to-amplitude converter that returns a signed 10-bit sine sample. The sine is never stored directly. The converter folds the phase into a single quarter wave, using mirror symmetry about the quarter point and odd symmetry about the half period.

Inside that quarter the converter rebuilds the magnitude from three parts: a straight-line term computed from the folded phase, a 16-entry coarse table holding one level per phase segment for the sine-minus-line difference, and a 6-bit signed residue table that holds what the coarse level misses. The contents of both tables are computed at elaboration. The sum is then signed according to the half period.

A new tuning word takes effect at the next clock edge. The amplitude leaves a register stage and is qualified by a valid flag once the pipeline has filled after reset.

Top module: `compressed_sine_dds`

## Requirements
- R1: While reset is high at a clock edge, the phase register clears to zero and `amp` and `amp_valid` go to zero. After release the phase starts counting from zero.
- R2: On every edge without reset, the phase advances by the `tune_word` present before that edge, modulo 2^32. The converter uses only phase bits 31:20, called k.
- R3: The amplitude for the phase value held after edge e appears on `amp` after edge e+3. `amp_valid` is low for the first two edges after reset release, rises at the third edge and then stays high until the next reset.
- R4: Every valid `amp` lies within ±1 of round(511·sin(2π(k+0.5)/4096)), with rounding half away from zero.
- R5: For k in 0..1023, the amplitude at phase 2047−k equals the amplitude at k exactly. The second quarter reads the table with the 10-bit in-quarter phase inverted.
- R6: For k in 0..2047, the amplitude at k+2048 is the exact two's-complement negation of the amplitude at k. Bit 11 of the truncated phase selects negation.
- R7: `amp` stays in −511..+511 and never takes the code −512.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| tune_word | input | 32 | Phase increment added each cycle |
| amp | output | 10 | Signed sine sample, two's complement |
| amp_valid | output | 1 | High once `amp` carries a converted sample |

## Verification
The phase register reacts one edge after a tuning word is applied. The fold, table-sum and sign stages add three more edges, so a sample reflects the phase held three edges earlier. The bench keeps its own phase model, updated with the word it drove before each edge, in a four-deep history. After every edge it samples `amp` at the falling edge and compares it with the model phase from three edges back. It checks `amp_valid` against an edge count that restarts at each reset release. A unit-step sweep records every one of the 4096 truncated phases, and the mirror and negation checks then run on that record.

// File: rtl/cdds_pkg.sv
package cdds_pkg;

    // pi/2 in unsigned Q28
    localparam longint HALF_PI_Q28 = 64'sd421657428;

    // tag that travels beside the datapath
    typedef struct packed {
        logic vld;
        logic neg;
    } stage_tag_t;

    // sine of a Q28 angle in [0, pi/2], Q28 result, odd Taylor series
    function automatic longint sin_q28(input longint x);
        longint x2;
        longint term;
        longint acc;
        x2   = (x * x) >>> 28;
        term = x;
        acc  = x;
        for (int k = 1; k <= 8; k++) begin
            term = -((term * x2) >>> 28) / longint'((2 * k) * (2 * k + 1));
            acc  = acc + term;
        end
        return acc;
    endfunction

    // rounded quarter-wave magnitude at folded phase p (centre of the step)
    function automatic int quarter_mag(input int p, input int qpw, input int peak);
        longint ang;
        longint s;
        ang = (HALF_PI_Q28 * longint'(2 * p + 1)) >>> (qpw + 1);
        s   = sin_q28(ang);
        return int'((s * longint'(peak) + (64'sd1 <<< 27)) >>> 28);
    endfunction

    // straight-line part of the magnitude
    function automatic int line_term(input int p, input int qpw, input int peak);
        return int'((longint'(p) * longint'(peak)) >>> qpw);
    endfunction

    function automatic int bend(input int p, input int qpw, input int peak);
        return quarter_mag(p, qpw, peak) - line_term(p, qpw, peak);
    endfunction

    // coarse level of a segment: the difference at its midpoint
    function automatic int coarse_level(input int seg, input int segw,
                                        input int qpw, input int peak);
        int span;
        span = 1 << (qpw - segw);
        return bend(seg * span + span / 2, qpw, peak);
    endfunction

    // residue left after the coarse level
    function automatic int residue(input int p, input int segw,
                                   input int qpw, input int peak);
        return bend(p, qpw, peak) - coarse_level(p >> (qpw - segw), segw, qpw, peak);
    endfunction

endpackage

// File: rtl/cdds_phase_acc.sv
module cdds_phase_acc #(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ACC_W-1:0] step,
    output logic [ACC_W-1:0] phase
);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= '0;
        end else begin
            phase <= phase + step;
        end
    end

    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> phase == $past(phase) + $past(step)); // R2

endmodule

// File: rtl/cdds_quad_fold.sv
module cdds_quad_fold
    import cdds_pkg::*;
#(
    parameter int PH_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PH_W-1:0]   ph,
    output logic [PH_W-3:0]   qidx,
    output stage_tag_t        tag
);

    localparam int QP_W = PH_W - 2;

    logic            mirror;
    logic            lower_half;
    logic [QP_W-1:0] offset;

    always_comb begin
        lower_half = ph[PH_W-1];
        mirror     = ph[PH_W-2];
        offset     = ph[QP_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            qidx <= '0;
            tag  <= '0;
        end else begin
            qidx    <= mirror ? ~offset : offset;
            tag.neg <= lower_half;
            tag.vld <= 1'b1;
        end
    end

endmodule

// File: rtl/cdds_sine_mapper.sv
module cdds_sine_mapper
    import cdds_pkg::*;
#(
    parameter int QP_W  = 10,
    parameter int SEG_W = 4,
    parameter int ERR_W = 6,
    parameter int MAG_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [QP_W-1:0]  qidx,
    input  stage_tag_t       tag_in,
    output logic [MAG_W-1:0] mag,
    output stage_tag_t       tag_out
);

    localparam int NSEG  = 1 << SEG_W;
    localparam int DEPTH = 1 << QP_W;
    localparam int PEAK  = (1 << MAG_W) - 1;
    localparam int CW    = MAG_W + 1;
    localparam int SUM_W = MAG_W + 2;
    localparam int PR_W  = QP_W + MAG_W;

    logic signed [CW-1:0]    coarse_rom [NSEG];
    logic signed [ERR_W-1:0] resid_rom  [DEPTH];

    for (genvar s = 0; s < NSEG; s++) begin : g_coarse
        localparam int CVAL = coarse_level(s, SEG_W, QP_W, PEAK);
        assign coarse_rom[s] = CW'(CVAL);
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_resid
        localparam int RVAL = residue(i, SEG_W, QP_W, PEAK);
        assign resid_rom[i] = ERR_W'(RVAL);
    end

    logic [PR_W-1:0]          prod;
    logic [MAG_W-1:0]         line_v;
    logic signed [CW-1:0]     coarse_v;
    logic signed [ERR_W-1:0]  resid_v;
    logic signed [SUM_W-1:0]  total;
    logic signed [SUM_W-1:0]  total_q;

    always_comb begin
        // idx * (2^MAG_W - 1) without a multiplier
        prod     = {qidx, {MAG_W{1'b0}}} - {{MAG_W{1'b0}}, qidx};
        line_v   = prod[PR_W-1:QP_W];
        coarse_v = coarse_rom[qidx[QP_W-1 -: SEG_W]];
        resid_v  = resid_rom[qidx];
        total    = $signed({2'b00, line_v})
                 + $signed({{(SUM_W-CW){coarse_v[CW-1]}}, coarse_v})
                 + $signed({{(SUM_W-ERR_W){resid_v[ERR_W-1]}}, resid_v});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            total_q <= '0;
            tag_out <= '0;
        end else begin
            total_q <= total;
            tag_out <= tag_in;
        end
    end

    assign mag = total_q[MAG_W-1:0];

    AST_MAG_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        total_q >= 0 && total_q <= SUM_W'(PEAK)); // R4

endmodule

// File: rtl/compressed_sine_dds.sv
module compressed_sine_dds
    import cdds_pkg::*;
#(
    parameter int ACC_W = 32,
    parameter int PH_W  = 12,
    parameter int AMP_W = 10,
    parameter int SEG_W = 4,
    parameter int ERR_W = 6
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [ACC_W-1:0]        tune_word,
    output logic signed [AMP_W-1:0] amp,
    output logic                    amp_valid
);

    localparam int QP_W  = PH_W - 2;
    localparam int MAG_W = AMP_W - 1;

    logic [ACC_W-1:0] phase;
    logic [QP_W-1:0]  qidx;
    logic [MAG_W-1:0] mag;
    stage_tag_t       tag_f;
    stage_tag_t       tag_m;

    cdds_phase_acc #(.ACC_W(ACC_W)) u_acc (
        .clk   (clk),
        .rst   (rst),
        .step  (tune_word),
        .phase (phase)
    );

    cdds_quad_fold #(.PH_W(PH_W)) u_fold (
        .clk  (clk),
        .rst  (rst),
        .ph   (phase[ACC_W-1 -: PH_W]),
        .qidx (qidx),
        .tag  (tag_f)
    );

    cdds_sine_mapper #(
        .QP_W  (QP_W),
        .SEG_W (SEG_W),
        .ERR_W (ERR_W),
        .MAG_W (MAG_W)
    ) u_map (
        .clk     (clk),
        .rst     (rst),
        .qidx    (qidx),
        .tag_in  (tag_f),
        .mag     (mag),
        .tag_out (tag_m)
    );

    logic [AMP_W-1:0] pos_v;
    logic [AMP_W-1:0] signed_v;

    always_comb begin
        pos_v    = {1'b0, mag};
        signed_v = tag_m.neg ? (~pos_v + 1'b1) : pos_v;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            amp       <= '0;
            amp_valid <= 1'b0;
        end else begin
            amp       <= signed'(signed_v);
            amp_valid <= tag_m.vld;
        end
    end

    AST_VALID_HOLDS: assert property (@(posedge clk) disable iff (rst)
        $past(amp_valid) |-> amp_valid); // R3

    AST_NO_MIN_CODE: assert property (@(posedge clk) disable iff (rst)
        amp_valid |-> amp != {1'b1, {MAG_W{1'b0}}}); // R7

    AST_NEG_HALF: assert property (@(posedge clk) disable iff (rst)
        (tag_m.vld && tag_m.neg && mag != '0) |=> amp < 0); // R6

    AST_POS_HALF: assert property (@(posedge clk) disable iff (rst)
        (tag_m.vld && !tag_m.neg) |=> amp >= 0); // R6

endmodule

// File: tb/tb_compressed_sine_dds.sv
`timescale 1ns/1ps
module tb_compressed_sine_dds;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [31:0]        tune_word = '0;
    logic signed [9:0]  amp;
    logic               amp_valid;

    int          n_chk  = 0;
    int          n_fail = 0;
    int          e      = 0;
    bit          done   = 1'b0;
    logic [31:0] a_model;
    logic [31:0] hist [4];
    int          tab  [4096];

    compressed_sine_dds dut (
        .clk       (clk),
        .rst       (rst),
        .tune_word (tune_word),
        .amp       (amp),
        .amp_valid (amp_valid)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int ref_amp(input int k);
        real v;
        v = 511.0 * $sin(2.0 * 3.14159265358979 * (real'(k) + 0.5) / 4096.0);
        return (v >= 0.0) ? $rtoi(v + 0.5) : $rtoi(v - 0.5);
    endfunction

    // R1: reset clears outputs; bench model restarts at zero
    task automatic do_reset();
        rst = 1'b1;
        repeat (3) begin
            @(posedge clk);
            @(negedge clk);
        end
        chk(amp_valid == 1'b0, "R1 valid in reset", int'(amp_valid), 0);
        chk(amp == 0, "R1 amp in reset", int'(amp), 0);
        rst     = 1'b0;
        e       = 0;
        a_model = '0;
        hist[0] = '0;
    endtask

    // one edge: R2 phase model, R3 latency/valid, R4 accuracy, R7 range
    task automatic step(input logic [31:0] t, input bit record);
        int k;
        int exp;
        int d;
        tune_word = t;
        @(posedge clk);
        @(negedge clk);
        e++;
        a_model     = a_model + t;
        hist[e % 4] = a_model;
        chk(amp_valid == (e >= 3), "R3 valid timing", int'(amp_valid), int'(e >= 3));
        if (e >= 3) begin
            k   = int'(hist[(e - 3) % 4][31:20]);
            exp = ref_amp(k);
            d   = int'(amp) - exp;
            chk(d <= 1 && d >= -1, "R4 amplitude (R2 phase model)", int'(amp), exp);
            chk(int'(amp) >= -511 && int'(amp) <= 511, "R7 range", int'(amp), 0);
            if (record) tab[k] = int'(amp);
        end
    endtask

    initial begin
        do_reset();
        // R1: first sample after release is phase zero
        for (int i = 0; i < 4100; i++) step(32'h0010_0000, 1'b1);
        // R5: mirror between first and second quarter
        for (int k = 0; k < 1024; k++)
            chk(tab[2047 - k] == tab[k], "R5 quarter mirror", tab[2047 - k], tab[k]);
        // R6: second half is the negation of the first
        for (int k = 0; k < 2048; k++)
            chk(tab[k + 2048] == -tab[k], "R6 half negation", tab[k + 2048], -tab[k]);
        for (int i = 0; i < 600; i++) step(32'h1234_5678, 1'b0);
        for (int i = 0; i < 20; i++)  step(32'h0000_0000, 1'b0);
        for (int i = 0; i < 300; i++) step(32'hFFF0_0000, 1'b0);
        for (int i = 0; i < 40; i++)  step(32'h8000_0001, 1'b0);
        // R1: reset in the middle of a run
        tune_word = 32'h0ABC_DEF1;
        do_reset();
        for (int i = 0; i < 60; i++)  step(32'h0800_0001, 1'b0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule